// File: doc/BRIEF.md
# Two-Digit Decimal Counter

This block counts clock edges in decimal, from 00 up to 99 and then back to 00. It holds two 4-bit binary-coded-decimal digits, a ones digit and a tens digit. Each digit runs from 0 to 9 and then returns to 0. The tens digit moves only on the edge where the ones digit returns to 0.

An enable input gates every step: while it is low both digits hold their values. A clear input is sampled on the clock edge and zeroes both digits. Clear has priority over enable.

Each digit finds its wrap point by looking at only two bits, its top bit and its bottom bit. Both are set first at nine, and on that edge the digit loads 0000. The carry into the tens digit is the enable ANDed with that same nine-detect on the ones digit.

Top module: `bcd2_counter`

## Requirements
- R1: When `clr` is high at a rising clock edge, both `ones` and `tens` are 0 after that edge, whatever the value of `en`.
- R2: When `clr` is low and `en` is low at a rising edge, both `ones` and `tens` keep their values.
- R3: When `clr` is low, `en` is high and `ones` is 0 to 8, `ones` rises by one at the edge.
- R4: When `clr` is low, `en` is high and `ones` is 9 (binary 1001), `ones` becomes 0 at the edge.
- R5: `tens` rises by one at an edge only when `en` is high and `ones` is 9. With `ones` at 0 to 8, or with `en` low, `tens` holds.
- R6: From 99, one enabled edge without clear gives 00. From 09 an enabled edge gives 10, and from 19 it gives 20.
- R7: After a clear, each digit always holds a value from 0 to 9. Digit bit 3 is the most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Rising-edge clock |
| clr  | input  | 1 | Clear to 00, sampled on the clock edge; has priority over `en` |
| en   | input  | 1 | Count enable |
| ones | output | 4 | Ones digit in BCD |
| tens | output | 4 | Tens digit in BCD |

## Verification
Two operations can meet on one edge: a clear and an enabled carry. The bench sets up a carry, at 09 and again at 99, and then raises `clr` together with `en` on the edge where the carry would happen. The result is judged correct only if both digits read 0. A reading of 10 would show that the tens carry leaked past the clear. The bench also runs more than a hundred cycles with `en` dropping at intervals and compares every edge with a decimal model, so holds at 9, carries and the full 99-to-00 wrap are all met under gated counting.

// File: rtl/bcd2_counter.sv
module bcd2_counter (
  input  logic       clk,
  input  logic       clr,
  input  logic       en,
  output logic [3:0] ones,
  output logic [3:0] tens
);

  logic ones_at_nine;
  logic tens_at_nine;
  logic tens_step;

  assign ones_at_nine = ones[3] & ones[0];
  assign tens_at_nine = tens[3] & tens[0];
  assign tens_step    = en & ones_at_nine;

  always_ff @(posedge clk) begin
    if (clr)
      ones <= 4'd0;
    else if (en)
      ones <= ones_at_nine ? 4'd0 : ones + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (clr)
      tens <= 4'd0;
    else if (tens_step)
      tens <= tens_at_nine ? 4'd0 : tens + 4'd1;
  end

endmodule

// File: rtl/bcd2_counter_chk.sv
module bcd2_counter_chk (
  input logic       clk,
  input logic       clr,
  input logic       en,
  input logic [3:0] ones,
  input logic [3:0] tens
);

  logic armed = 1'b0;
  logic live1 = 1'b0;
  logic live2 = 1'b0;

  always_ff @(posedge clk) begin
    armed <= armed | clr;
    live1 <= armed;
    live2 <= live1;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!live2)
    clr |=> (ones == 4'd0 && tens == 4'd0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (clr || !live2)
    !en |=> ($stable(ones) && $stable(tens))); // R2
  AST_ONES_STEP: assert property (@(posedge clk) disable iff (clr || !live2)
    (en && ones != 4'd9) |=> (ones == $past(ones) + 4'd1)); // R3
  AST_ONES_WRAP: assert property (@(posedge clk) disable iff (clr || !live2)
    (en && ones == 4'd9) |=> (ones == 4'd0)); // R4
  AST_TENS_STEP: assert property (@(posedge clk) disable iff (clr || !live2)
    (en && ones == 4'd9 && tens != 4'd9) |=> (tens == $past(tens) + 4'd1)); // R5
  AST_TENS_HOLD: assert property (@(posedge clk) disable iff (clr || !live2)
    (en && ones != 4'd9) |=> $stable(tens)); // R5
  AST_FULL_WRAP: assert property (@(posedge clk) disable iff (clr || !live2)
    (en && ones == 4'd9 && tens == 4'd9) |=> (ones == 4'd0 && tens == 4'd0)); // R6
  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!live2)
    (ones <= 4'd9 && tens <= 4'd9)); // R7

endmodule

bind bcd2_counter bcd2_counter_chk chk_i (
  .clk(clk), .clr(clr), .en(en), .ones(ones), .tens(tens)
);

// File: tb/bcd2_counter_tb_top.sv
module bcd2_counter_tb_top;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] ones;
  logic [3:0] tens;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  bcd2_counter dut_i (.clk(clk), .clr(clr), .en(en), .ones(ones), .tens(tens));

  // row = {clr, en, expected ones, expected tens}
  localparam int ROWS = 16;
  localparam logic [9:0] VEC [ROWS] = '{
    {1'b1, 1'b0, 4'd0, 4'd0},
    {1'b0, 1'b1, 4'd1, 4'd0},
    {1'b0, 1'b1, 4'd2, 4'd0},
    {1'b0, 1'b0, 4'd2, 4'd0},
    {1'b0, 1'b1, 4'd3, 4'd0},
    {1'b0, 1'b1, 4'd4, 4'd0},
    {1'b0, 1'b1, 4'd5, 4'd0},
    {1'b0, 1'b1, 4'd6, 4'd0},
    {1'b0, 1'b1, 4'd7, 4'd0},
    {1'b0, 1'b1, 4'd8, 4'd0},
    {1'b0, 1'b1, 4'd9, 4'd0},
    {1'b0, 1'b0, 4'd9, 4'd0},
    {1'b0, 1'b1, 4'd0, 4'd1},
    {1'b0, 1'b1, 4'd1, 4'd1},
    {1'b1, 1'b1, 4'd0, 4'd0},
    {1'b0, 1'b1, 4'd1, 4'd0}
  };

  task automatic step(input logic c, input logic e);
    clr = c;
    en  = e;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] eo, input logic [3:0] et);
    checks++;
    if (ones !== eo || tens !== et) begin
      failures++;
      $display("FAIL %s: got %0d%0d expected %0d%0d", tag, tens, ones, et, eo);
    end
  endtask

  initial begin
    int model;
    @(negedge clk);
    step(1'b1, 1'b0);
    chk("R1 state after clear", 4'd0, 4'd0);

    for (int i = 0; i < ROWS; i++) begin
      step(VEC[i][9], VEC[i][8]);
      chk($sformatf("table row %0d R1 R2 R3 R4 R5", i), VEC[i][7:4], VEC[i][3:0]);
    end

    // gated run over more than a hundred edges against a decimal model
    step(1'b1, 1'b0);
    model = 0;
    for (int i = 0; i < 130; i++) begin
      logic e;
      e = (i % 7) != 3;
      step(1'b0, e);
      if (e) model = (model + 1) % 100;
      chk($sformatf("R3 R5 R6 gated run edge %0d", i), 4'(model % 10), 4'(model / 10));
    end

    // 09 -> 10 and 19 -> 20
    step(1'b1, 1'b0);
    for (int i = 0; i < 9; i++) step(1'b0, 1'b1);
    chk("R4 reach 09", 4'd9, 4'd0);
    step(1'b0, 1'b1);
    chk("R6 09 to 10", 4'd0, 4'd1);
    for (int i = 0; i < 9; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    chk("R6 19 to 20", 4'd0, 4'd2);

    // clear meets a carry at 09
    step(1'b1, 1'b0);
    for (int i = 0; i < 9; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R1 clear with carry at 09", 4'd0, 4'd0);

    // 99 -> 00
    for (int i = 0; i < 99; i++) step(1'b0, 1'b1);
    chk("R5 reach 99", 4'd9, 4'd9);
    step(1'b0, 1'b0);
    chk("R2 hold at 99", 4'd9, 4'd9);
    step(1'b0, 1'b1);
    chk("R6 99 to 00", 4'd0, 4'd0);

    // clear meets a carry at 99
    for (int i = 0; i < 99; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R1 clear with carry at 99", 4'd0, 4'd0);
    step(1'b0, 1'b1);
    chk("R7 count resumes after clear", 4'd1, 4'd0);

    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got hung run expected completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule